// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory built for a shared data bus where reads and writes follow each other with no idle cycle between them. A command is sampled at a rising clock edge. A read returns its word on the output after the following edge. A write takes its data from the bus at the edge two cycles after its command. Because a write's data arrives in the same bus slot where a read's data would appear, reads and writes can alternate on every cycle.

Each 32-bit word has four byte lanes, and each lane has its own active-low write strobe. A clock-enable input stalls the whole pipeline. An output-enable input, which acts without waiting for a clock edge, gates the output drive. A sleep input puts the core into a retention state two cycles after it rises and wakes it two cycles after it falls. If a read targets an address whose write data has not yet reached the array, the core returns the pending bytes. Burst address sequencing is done outside this block.

Top module: `zt_sram_core`

## Requirements
- R1: At a rising edge with `cke_n`=0, `cs_n`=0 and the core awake, the core registers a command: a read if `we_n`=1, a write if `we_n`=0, together with `addr` and `bw_n`.
- R2: For a read registered at edge k, the word appears on `dq_o` with `dq_oe`=1 after edge k+1. It stays there until the next edge with `cke_n`=0.
- R3: For a write registered at edge k, `wdata` is sampled at the second later edge with `cke_n`=0. That edge is k+2 when no stall comes between.
- R4: `bw_n[i]`=0 writes bits [8i+7:8i] of the word. Lanes whose strobe is 1 keep their stored value.
- R5: While `cke_n`=1, every pipeline register, the output word and the output valid state hold their values. All synchronous inputs, including `wdata`, are ignored.
- R6: `dq_oe` is 0 whenever `oe_n`=1, without waiting for a clock edge. With `oe_n`=0, read data is driven.
- R7: If `sleep` is sampled 1 at edge k, the core is asleep after edge k+1. While it is asleep, commands are taken as deselects, `dq_oe` is 0, and the stored contents are kept.
- R8: If `sleep` is sampled 0 at edge k, the core is awake after edge k+1 and accepts commands again.
- R9: A cycle with `cs_n`=1 does no access, and `dq_oe` is 0 in its output slot. After reset `dq_oe` is 0.
- R10: A read registered one edge after a write to the same address returns that write's data in the strobed lanes and the older array bytes in the other lanes.
- R11: Reads and writes in any order, issued back to back on every cycle, each complete with no inserted idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline (array not cleared) |
| cke_n | input | 1 | Active-low clock enable; 1 stalls the core |
| cs_n | input | 1 | Active-low select; 1 gives a deselect cycle |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | 4 | Active-low byte-lane write strobes |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data, sampled two advancing edges after its command |
| oe_n | input | 1 | Active-low output enable, acts without a clock edge |
| sleep | input | 1 | Retention request, takes effect two edges later |
| dq_o | output | 32 | Read data word |
| dq_oe | output | 1 | High when `dq_o` should drive the bus |

## Verification
The bench first fills every address with full-word writes. It then runs directed sequences: partial-strobe writes, which separate lanes that are written from lanes that are kept; a write followed at once by a read of the same address, which separates forwarded data from stale array data; stalls held across the data slot, which show whether `wdata` is taken at the stalled edge or at the next advancing one; and sleep pulses with reads issued around their edges, which pin the two-cycle entry and exit. A long random mix of reads, writes, deselects, stalls, output-enable toggles and sleep requests is then checked every cycle against a behavioural model. This mix catches ordering errors that only appear when the operations interleave.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int ZT_ADDR_W = 6;
    localparam int ZT_LANES  = 4;
    localparam int ZT_LANE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_sram_lane.sv
module zt_sram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/zt_sram_doze.sv
module zt_sram_doze (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);
    typedef struct packed {
        logic [1:0] sh;
        logic [1:0] live;
    } doze_t;

    doze_t doze_d, doze_q;

    always_comb begin
        doze_d      = doze_q;
        doze_d.sh   = {doze_q.sh[0], sleep};
        doze_d.live = (doze_q.live == 2'd2) ? doze_q.live : doze_q.live + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) doze_q <= '0;
        else        doze_q <= doze_d;
    end

    assign asleep = doze_q.sh[1];

    assert_enter_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_q.live == 2'd2) && $past(sleep, 2) |-> asleep);
    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_q.live == 2'd2) && !$past(sleep, 2) |-> !asleep);
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = ZT_ADDR_W,
    parameter int LANES  = ZT_LANES,
    parameter int LANE_W = ZT_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    cs_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        stage_t            s2;
        logic [DATA_W-1:0] dout;
        logic              rvld;
    } core_t;

    core_t core_d, core_q;

    logic              adv;
    logic              asleep;
    logic              fwd_hit;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] merged;

    assign adv     = !cke_n;
    assign fwd_hit = (core_q.s2.op == OP_WRITE) && (core_q.s2.addr == core_q.s1.addr);

    zt_sram_doze u_doze (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .asleep (asleep)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        zt_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .wr_en   (lane_we[i]),
            .wr_addr (core_q.s2.addr),
            .wr_data (wdata[i*LANE_W +: LANE_W]),
            .rd_addr (core_q.s1.addr),
            .rd_data (arr_rd[i*LANE_W +: LANE_W])
        );
        assign lane_we[i] = adv && (core_q.s2.op == OP_WRITE) && core_q.s2.bw[i];
        assign merged[i*LANE_W +: LANE_W] = (fwd_hit && core_q.s2.bw[i])
                                          ? wdata[i*LANE_W +: LANE_W]
                                          : arr_rd[i*LANE_W +: LANE_W];
    end

    always_comb begin
        core_d = core_q;
        if (adv) begin
            core_d.s2      = core_q.s1;
            core_d.s1.addr = addr;
            core_d.s1.bw   = ~bw_n;
            if (!cs_n && !asleep) core_d.s1.op = we_n ? OP_READ : OP_WRITE;
            else                  core_d.s1.op = OP_IDLE;
            core_d.rvld = (core_q.s1.op == OP_READ);
            if (core_q.s1.op == OP_READ) core_d.dout = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign dq_o  = core_q.dout;
    assign dq_oe = core_q.rvld && !oe_n && !asleep;

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(core_q));
    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (core_q.s1.op != OP_READ) |=> !dq_oe);
    assert_forward_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (core_q.s1.op == OP_READ) && fwd_hit && (core_q.s2.bw == '1)
        |=> dq_o == $past(wdata));
    assert_array_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (core_q.s1.op == OP_READ) && (core_q.s2.op != OP_WRITE)
        |=> dq_o == $past(arr_rd));
endmodule

// File: tb/zt_sram_core_test.sv
`timescale 1ns/1ps
module zt_sram_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [3:0]  bw_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] dq_o;
    logic        dq_oe;

    int compared = 0, mismatched = 0;
    string tag = "R9";

    // model state
    logic [31:0] mmem [64];
    int          s1_op = 0, s2_op = 0;
    logic [5:0]  s1_a = '0, s2_a = '0;
    logic [3:0]  s1_bw = '0, s2_bw = '0;
    logic [31:0] e_dout = '0;
    logic        e_rvld = 1'b0, sh0 = 1'b0, sh1 = 1'b0;

    always #4 clk = ~clk;

    zt_sram_core uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [31:0] lane_merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] en);
        logic [31:0] r = old_w;
        for (int i = 0; i < 4; i++) if (en[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    task automatic model_edge();
        if (!cke_n) begin
            if (s2_op == 2) mmem[s2_a] = lane_merge(mmem[s2_a], wdata, s2_bw);
            e_rvld = (s1_op == 1);
            if (s1_op == 1) e_dout = mmem[s1_a];
            s2_op = s1_op; s2_a = s1_a; s2_bw = s1_bw;
            s1_op = (!cs_n && !sh1) ? (we_n ? 1 : 2) : 0;
            s1_a = addr; s1_bw = ~bw_n;
        end
        sh1 = sh0;
        sh0 = sleep;
    endtask

    task automatic check(logic ok, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic exp_oe;
        exp_oe = e_rvld && !oe_n && !sh1;
        check(dq_oe == exp_oe, "dq_oe", {31'd0, dq_oe}, {31'd0, exp_oe});
        if (exp_oe) check(dq_o == e_dout, "dq_o", dq_o, e_dout);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(logic c, logic w, logic [5:0] a, logic [3:0] b);
        cke_n = 1'b0; cs_n = c; we_n = w; addr = a; bw_n = b; wdata = $urandom;
        cycle();
    endtask

    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R9";
        check(dq_oe == 1'b0, "reset dq_oe", {31'd0, dq_oe}, 32'd0);

        tag = "R3";                                     // fill every word
        for (int a = 0; a < 64; a++) issue(1'b0, 1'b0, 6'(a), 4'h0);
        issue(1'b1, 1'b1, 0, 4'hF); issue(1'b1, 1'b1, 0, 4'hF);

        tag = "R1";                                     // reads of several words
        for (int a = 0; a < 8; a++) issue(1'b0, 1'b1, 6'(a * 7), 4'hF);
        tag = "R2";
        issue(1'b1, 1'b1, 0, 4'hF); issue(1'b1, 1'b1, 0, 4'hF);

        tag = "R4";                                     // partial strobes
        issue(1'b0, 1'b0, 6'd5, 4'b1010);
        issue(1'b0, 1'b0, 6'd9, 4'b0111);
        issue(1'b1, 1'b1, 0, 4'hF);
        issue(1'b0, 1'b1, 6'd5, 4'hF);
        issue(1'b0, 1'b1, 6'd9, 4'hF);
        issue(1'b1, 1'b1, 0, 4'hF); issue(1'b1, 1'b1, 0, 4'hF);

        tag = "R10";                                    // write then read same word
        issue(1'b0, 1'b0, 6'd12, 4'b1100);
        issue(1'b0, 1'b1, 6'd12, 4'hF);
        issue(1'b0, 1'b0, 6'd13, 4'h0);
        issue(1'b0, 1'b1, 6'd13, 4'hF);
        issue(1'b1, 1'b1, 0, 4'hF); issue(1'b1, 1'b1, 0, 4'hF);

        tag = "R5";                                     // stall across data slot
        issue(1'b0, 1'b0, 6'd20, 4'h0);
        issue(1'b0, 1'b1, 6'd21, 4'hF);
        cke_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cs_n = 1'b0; we_n = $urandom_range(0, 1); addr = $urandom; wdata = $urandom;
            cycle();
        end
        issue(1'b1, 1'b1, 0, 4'hF);
        issue(1'b0, 1'b1, 6'd20, 4'hF);
        issue(1'b1, 1'b1, 0, 4'hF); issue(1'b1, 1'b1, 0, 4'hF);

        tag = "R6";                                     // asynchronous output enable
        issue(1'b0, 1'b1, 6'd3, 4'hF);
        issue(1'b1, 1'b1, 0, 4'hF);
        oe_n = 1'b1; #1;
        check(dq_oe == 1'b0, "oe_n high", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        check(dq_oe == 1'b1, "oe_n low", {31'd0, dq_oe}, 32'd1);

        tag = "R9";
        issue(1'b1, 1'b0, 6'd4, 4'h0);
        issue(1'b1, 1'b1, 6'd4, 4'hF);

        tag = "R7";                                     // sleep entry with reads
        sleep = 1'b1;
        for (int s = 0; s < 6; s++) issue(1'b0, 1'b1, 6'(s), 4'hF);
        issue(1'b0, 1'b0, 6'd1, 4'h0);
        tag = "R8";
        sleep = 1'b0;
        for (int s = 0; s < 6; s++) issue(1'b0, 1'b1, 6'(s), 4'hF);

        tag = "R11";                                    // random mix
        for (int n = 0; n < 4000; n++) begin
            cke_n = ($urandom_range(0, 9) == 0);
            cs_n  = ($urandom_range(0, 7) == 0);
            we_n  = $urandom_range(0, 1);
            addr  = 6'($urandom_range(0, 15));
            bw_n  = 4'($urandom);
            wdata = $urandom;
            oe_n  = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 63) == 0) sleep = ~sleep;
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule